// File: doc/BRIEF.md
# CPU Exception Entry and Return Sequencer

This block sequences exception entry and exception return for a 32-bit in-order processor core. The core reports exception requests from the faulting instruction's stage. These are a breakpoint, a system call, a divide by zero, and a data access that either hits an unmapped address or is misaligned. The block picks one request and answers the following cycle with two commands. The first is a one-cycle redirect to the handler address. The second is a one-cycle register-file write that saves the faulting PC as the return address.

The block also owns four control registers: a three-bit interrupt-enable stack, the interrupt-pending bits, and separate vector bases for ordinary and debug handlers. A normal exception pushes the live enable into one save slot, and a breakpoint pushes it into another. A return branch pops the matching slot, chosen by the register the branch goes through. Pending bits are set by interrupt sources and cleared by software with write-one-to-clear. Decode, the register file, the data path and interrupt arbitration belong to the surrounding core.

Top module: `exc_seq_ctrl`

## Requirements
- R1: After reset the enable stack, the pending bits and both vector bases read zero, and `redir_valid` and `rf_we` are low.
- R2: A system call, divide-by-zero or data bus error request makes the block write the request-cycle `fault_pc` to register 30 (`rf_waddr` = 30) one cycle later.
- R3: A breakpoint request makes the block write the request-cycle `fault_pc` to register 31 one cycle later.
- R4: On a non-breakpoint exception, the enable stack becomes {0, old bit0, 0}, so the live enable bit0 is cleared and the old enable is held in bit1.
- R5: On a breakpoint, the enable stack becomes {old bit0, 0, 0}.
- R6: A non-breakpoint redirect goes to `eba` + ID*32. The IDs are: breakpoint 1, data bus error 4, divide by zero 5, system call 7.
- R7: A breakpoint redirect goes to `deba` + 1*32.
- R8: A return (`ret_valid`) through register 30 sets the stack to {0,0,old bit1}. A return through register 31 sets it to {0,0,old bit2}. A return through any other register leaves the stack unchanged.
- R9: The pending register gains every bit of `irq_raise`. A write to it (`csr_sel` = 1) clears each bit written as 1 and leaves the bits written as 0 alone. When one bit is raised and cleared in the same cycle, the raise wins.
- R10: CSR writes select a register with `csr_sel`: 0 is the enable stack (takes `csr_wdata[2:0]`), 2 is `eba`, 3 is `deba`. Each stores the value as given. Each register is visible on its output port the cycle after the write.
- R11: An unmapped access and a misaligned access each raise the data bus error exception (ID 4).
- R12: Among simultaneous requests the lowest ID wins. An exception overrides a same-cycle return or enable write in updating the stack. A return through register 30 or 31 overrides a same-cycle enable write. The redirect uses the vector base held before a same-cycle base write.
- R13: `redir_valid` and `rf_we` are high in exactly the cycles that follow a cycle with at least one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_req | input | 1 | Breakpoint request |
| scall_req | input | 1 | System call request |
| div0_req | input | 1 | Divide-by-zero request |
| dbus_unmapped | input | 1 | Data access to an unmapped address |
| dbus_misalign | input | 1 | Misaligned data access |
| fault_pc | input | XLEN | PC of the faulting instruction |
| ret_valid | input | 1 | A return branch executes |
| ret_reg | input | RIDX_W | Register index the return branch goes through |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | CSR select (0 enable, 1 pending, 2 base, 3 debug base) |
| csr_wdata | input | XLEN | CSR write data |
| irq_raise | input | NIRQ | Interrupt lines that set pending bits |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | XLEN | Handler address |
| rf_we | output | 1 | Return-address write strobe |
| rf_waddr | output | RIDX_W | Return-address register index |
| rf_wdata | output | XLEN | Saved faulting PC |
| ie | output | 3 | Interrupt-enable stack |
| ip | output | NIRQ | Interrupt-pending bits |
| eba | output | XLEN | Ordinary exception vector base |
| deba | output | XLEN | Debug exception vector base |

## Verification
Software can write a control register in the same cycle that an exception request arrives, so an exception entry and a CSR write can fall in one cycle. The bench provokes this by asserting a system call together with a write to the vector base. It checks that the redirect used the old base and that the new base is kept afterwards. It also pairs an exception with an enable-stack write, and a return with an enable-stack write, and checks that the stack ends in the state the precedence rules give. Raise and clear of the same pending bit are also driven together.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int EID_W     = 3;
    localparam int NUM_EID   = 1 << EID_W;
    localparam int VEC_SHIFT = 5;
    localparam int REG_EXC   = 30;
    localparam int REG_BRK   = 31;
    localparam int IE_W      = 3;

    typedef enum logic [EID_W-1:0] {
        EID_RESET = 3'd0,
        EID_BREAK = 3'd1,
        EID_IBUS  = 3'd2,
        EID_WATCH = 3'd3,
        EID_DBUS  = 3'd4,
        EID_DIV0  = 3'd5,
        EID_IRQ   = 3'd6,
        EID_SCALL = 3'd7
    } exc_id_e;

    typedef enum logic [1:0] {
        CSEL_IE   = 2'd0,
        CSEL_IP   = 2'd1,
        CSEL_EBA  = 2'd2,
        CSEL_DEBA = 2'd3
    } csr_sel_e;

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         valid,
    output logic [W-1:0] id
);

    always_comb begin
        valid = |req;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                id = W'(i);
            end
        end
    end

endmodule

// File: rtl/exc_ie_next.sv
module exc_ie_next
    import exc_seq_pkg::*;
#(
    parameter int RIDX_W = 5
) (
    input  logic [IE_W-1:0]   ie_cur,
    input  logic              exc_valid,
    input  logic              exc_is_brk,
    input  logic              ret_valid,
    input  logic [RIDX_W-1:0] ret_reg,
    input  logic              ie_wr,
    input  logic [IE_W-1:0]   ie_wdata,
    output logic [IE_W-1:0]   ie_next
);

    logic ret_exc;
    logic ret_brk;

    always_comb begin
        ret_exc = ret_valid && (ret_reg == RIDX_W'(REG_EXC));
        ret_brk = ret_valid && (ret_reg == RIDX_W'(REG_BRK));
        ie_next = ie_cur;
        if (exc_valid) begin
            if (exc_is_brk) begin
                ie_next = {ie_cur[0], 2'b00};
            end else begin
                ie_next = {1'b0, ie_cur[0], 1'b0};
            end
        end else if (ret_exc) begin
            ie_next = {2'b00, ie_cur[1]};
        end else if (ret_brk) begin
            ie_next = {2'b00, ie_cur[2]};
        end else if (ie_wr) begin
            ie_next = ie_wdata;
        end
    end

endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
    import exc_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int NIRQ   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic              exc_is_brk,
    input  logic              ret_valid,
    input  logic [RIDX_W-1:0] ret_reg,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [NIRQ-1:0]   irq_raise,
    output logic [IE_W-1:0]   ie,
    output logic [NIRQ-1:0]   ip,
    output logic [XLEN-1:0]   eba,
    output logic [XLEN-1:0]   deba
);

    typedef struct packed {
        logic [IE_W-1:0] ie;
        logic [NIRQ-1:0] ip;
        logic [XLEN-1:0] eba;
        logic [XLEN-1:0] deba;
    } csr_state_t;

    csr_state_t      st_d;
    csr_state_t      st_q;
    logic [IE_W-1:0] ie_nx;
    logic            wr_ie;
    logic            wr_ip;
    logic            wr_eba;
    logic            wr_deba;
    logic [NIRQ-1:0] clr_mask;

    always_comb begin
        wr_ie   = csr_we && (csr_sel == CSEL_IE);
        wr_ip   = csr_we && (csr_sel == CSEL_IP);
        wr_eba  = csr_we && (csr_sel == CSEL_EBA);
        wr_deba = csr_we && (csr_sel == CSEL_DEBA);
    end

    exc_ie_next #(
        .RIDX_W(RIDX_W)
    ) u_ie (
        .ie_cur    (st_q.ie),
        .exc_valid (exc_valid),
        .exc_is_brk(exc_is_brk),
        .ret_valid (ret_valid),
        .ret_reg   (ret_reg),
        .ie_wr     (wr_ie),
        .ie_wdata  (csr_wdata[IE_W-1:0]),
        .ie_next   (ie_nx)
    );

    always_comb begin
        st_d     = st_q;
        clr_mask = wr_ip ? csr_wdata[NIRQ-1:0] : '0;
        st_d.ie  = ie_nx;
        st_d.ip  = (st_q.ip & ~clr_mask) | irq_raise;
        if (wr_eba) begin
            st_d.eba = csr_wdata;
        end
        if (wr_deba) begin
            st_d.deba = csr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ie   = st_q.ie;
    assign ip   = st_q.ip;
    assign eba  = st_q.eba;
    assign deba = st_q.deba;

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int NIRQ   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_req,
    input  logic              scall_req,
    input  logic              div0_req,
    input  logic              dbus_unmapped,
    input  logic              dbus_misalign,
    input  logic [XLEN-1:0]   fault_pc,
    input  logic              ret_valid,
    input  logic [RIDX_W-1:0] ret_reg,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [NIRQ-1:0]   irq_raise,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic [IE_W-1:0]   ie,
    output logic [NIRQ-1:0]   ip,
    output logic [XLEN-1:0]   eba,
    output logic [XLEN-1:0]   deba
);

    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   pc;
        logic [RIDX_W-1:0] waddr;
        logic [XLEN-1:0]   wdata;
    } cmd_t;

    logic [NUM_EID-1:0] req_vec;
    logic               exc_valid;
    logic [EID_W-1:0]   exc_id;
    logic               exc_is_brk;
    logic [XLEN-1:0]    vec_base;
    logic [XLEN-1:0]    vec_off;
    cmd_t               cmd_d;
    cmd_t               cmd_q;

    always_comb begin
        req_vec            = '0;
        req_vec[EID_BREAK] = brk_req;
        req_vec[EID_DBUS]  = dbus_unmapped | dbus_misalign;
        req_vec[EID_DIV0]  = div0_req;
        req_vec[EID_SCALL] = scall_req;
    end

    exc_prio_sel #(
        .N(NUM_EID)
    ) u_prio (
        .req  (req_vec),
        .valid(exc_valid),
        .id   (exc_id)
    );

    exc_csr_bank #(
        .XLEN  (XLEN),
        .RIDX_W(RIDX_W),
        .NIRQ  (NIRQ)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_valid (exc_valid),
        .exc_is_brk(exc_is_brk),
        .ret_valid (ret_valid),
        .ret_reg   (ret_reg),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .irq_raise (irq_raise),
        .ie        (ie),
        .ip        (ip),
        .eba       (eba),
        .deba      (deba)
    );

    always_comb begin
        exc_is_brk  = exc_valid && (exc_id == EID_BREAK);
        vec_base    = exc_is_brk ? deba : eba;
        vec_off     = XLEN'(exc_id) << VEC_SHIFT;
        cmd_d       = '0;
        cmd_d.valid = exc_valid;
        if (exc_valid) begin
            cmd_d.pc    = vec_base + vec_off;
            cmd_d.waddr = exc_is_brk ? RIDX_W'(REG_BRK) : RIDX_W'(REG_EXC);
            cmd_d.wdata = fault_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign redir_valid = cmd_q.valid;
    assign redir_pc    = cmd_q.pc;
    assign rf_we       = cmd_q.valid;
    assign rf_waddr    = cmd_q.waddr;
    assign rf_wdata    = cmd_q.wdata;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int NIRQ   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              brk_req,
    input logic              scall_req,
    input logic              div0_req,
    input logic              dbus_unmapped,
    input logic              dbus_misalign,
    input logic [XLEN-1:0]   fault_pc,
    input logic              ret_valid,
    input logic [RIDX_W-1:0] ret_reg,
    input logic              csr_we,
    input logic [1:0]        csr_sel,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [NIRQ-1:0]   irq_raise,
    input logic              redir_valid,
    input logic              rf_we,
    input logic [RIDX_W-1:0] rf_waddr,
    input logic [XLEN-1:0]   rf_wdata,
    input logic [2:0]        ie,
    input logic [NIRQ-1:0]   ip
);

    logic any_req;
    logic normal_req;
    logic ret_pop;
    logic ie_write;

    always_comb begin
        any_req    = brk_req | scall_req | div0_req | dbus_unmapped | dbus_misalign;
        normal_req = !brk_req && (scall_req | div0_req | dbus_unmapped | dbus_misalign);
        ret_pop    = ret_valid && (ret_reg == RIDX_W'(30) || ret_reg == RIDX_W'(31));
        ie_write   = csr_we && (csr_sel == 2'd0);
    end

    p_pulse_on_r13: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> (redir_valid && rf_we));

    p_pulse_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (!redir_valid && !rf_we));

    p_save_exc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        normal_req |=> (rf_waddr == RIDX_W'(30) && rf_wdata == $past(fault_pc)));

    p_save_brk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> (rf_waddr == RIDX_W'(31) && rf_wdata == $past(fault_pc)));

    p_ie_exc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        normal_req |=> (ie == {1'b0, $past(ie[0]), 1'b0}));

    p_ie_brk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> (ie == {$past(ie[0]), 2'b00}));

    p_ie_ret30_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_req && ret_valid && ret_reg == RIDX_W'(30)) |=> (ie == {2'b00, $past(ie[1])}));

    p_ie_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_req && !ret_pop && !ie_write) |=> $stable(ie));

    p_ip_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == 2'd1 && irq_raise == '0)
        |=> (ip == ($past(ip) & ~$past(csr_wdata[NIRQ-1:0]))));

endmodule

bind exc_seq_ctrl exc_seq_chk #(
    .XLEN  (XLEN),
    .RIDX_W(RIDX_W),
    .NIRQ  (NIRQ)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .brk_req      (brk_req),
    .scall_req    (scall_req),
    .div0_req     (div0_req),
    .dbus_unmapped(dbus_unmapped),
    .dbus_misalign(dbus_misalign),
    .fault_pc     (fault_pc),
    .ret_valid    (ret_valid),
    .ret_reg      (ret_reg),
    .csr_we       (csr_we),
    .csr_sel      (csr_sel),
    .csr_wdata    (csr_wdata),
    .irq_raise    (irq_raise),
    .redir_valid  (redir_valid),
    .rf_we        (rf_we),
    .rf_waddr     (rf_waddr),
    .rf_wdata     (rf_wdata),
    .ie           (ie),
    .ip           (ip)
);

// File: tb/sim_exc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_exc_seq_ctrl;

    localparam int XLEN = 32;
    localparam int RW   = 5;
    localparam int NIRQ = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            brk_req, scall_req, div0_req, dbus_unmapped, dbus_misalign;
    logic [XLEN-1:0] fault_pc;
    logic            ret_valid;
    logic [RW-1:0]   ret_reg;
    logic            csr_we;
    logic [1:0]      csr_sel;
    logic [XLEN-1:0] csr_wdata;
    logic [NIRQ-1:0] irq_raise;
    logic            redir_valid, rf_we;
    logic [XLEN-1:0] redir_pc, rf_wdata, eba, deba;
    logic [RW-1:0]   rf_waddr;
    logic [2:0]      ie;
    logic [NIRQ-1:0] ip;

    int nvec = 0;
    int nbad = 0;

    logic [2:0]      m_ie;
    logic [NIRQ-1:0] m_ip;
    logic [XLEN-1:0] m_eba, m_deba;

    always #2 clk = ~clk;

    exc_seq_ctrl #(.XLEN(XLEN), .RIDX_W(RW), .NIRQ(NIRQ)) u0 (
        .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .scall_req(scall_req),
        .div0_req(div0_req), .dbus_unmapped(dbus_unmapped), .dbus_misalign(dbus_misalign),
        .fault_pc(fault_pc), .ret_valid(ret_valid), .ret_reg(ret_reg),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .irq_raise(irq_raise),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .ie(ie), .ip(ip),
        .eba(eba), .deba(deba)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        brk_req = 0; scall_req = 0; div0_req = 0; dbus_unmapped = 0; dbus_misalign = 0;
        fault_pc = '0; ret_valid = 0; ret_reg = '0; csr_we = 0; csr_sel = '0;
        csr_wdata = '0; irq_raise = '0;
    endtask

    task automatic chk_csrs(input string req);
        chk(req, "ie", 32'(ie), 32'(m_ie));
        chk(req, "ip", ip, m_ip);
        chk(req, "eba", eba, m_eba);
        chk(req, "deba", deba, m_deba);
    endtask

    task automatic t_reset();
        chk("R1", "redir_valid", 32'(redir_valid), 0);
        chk("R1", "rf_we", 32'(rf_we), 0);
        chk_csrs("R1");
    endtask

    task automatic csr_wr(input logic [1:0] sel, input logic [31:0] d);
        csr_we = 1; csr_sel = sel; csr_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic t_csr_write();
        csr_wr(2'd2, 32'h0000_1000); m_eba = 32'h0000_1000;
        csr_wr(2'd3, 32'h0000_8000); m_deba = 32'h0000_8000;
        csr_wr(2'd0, 32'hFFFF_FFF9); m_ie = 3'b001;
        chk_csrs("R10");
    endtask

    // one exception; pulse checked the cycle after and gone the cycle after that
    task automatic exc(input string req, input logic b, input logic s, input logic d,
                       input logic um, input logic ma, input logic [31:0] pc,
                       input logic [31:0] exp_pc, input logic [4:0] exp_reg);
        brk_req = b; scall_req = s; div0_req = d; dbus_unmapped = um; dbus_misalign = ma;
        fault_pc = pc;
        @(negedge clk); idle();
        if (b) m_ie = {m_ie[0], 2'b00};
        else   m_ie = {1'b0, m_ie[0], 1'b0};
        chk(req, "redir_valid", 32'(redir_valid), 1);
        chk(req, "rf_we", 32'(rf_we), 1);
        chk(req, "redir_pc", redir_pc, exp_pc);
        chk(req, "rf_waddr", 32'(rf_waddr), 32'(exp_reg));
        chk(req, "rf_wdata", rf_wdata, pc);
        chk(req, "ie", 32'(ie), 32'(m_ie));
        @(negedge clk);
        chk("R13", "redir_valid drop", 32'(redir_valid), 0);
        chk("R13", "rf_we drop", 32'(rf_we), 0);
    endtask

    task automatic ret(input string req, input logic [4:0] r);
        ret_valid = 1; ret_reg = r;
        @(negedge clk); idle();
        if (r == 5'd30)      m_ie = {2'b00, m_ie[1]};
        else if (r == 5'd31) m_ie = {2'b00, m_ie[2]};
        chk(req, "ie after return", 32'(ie), 32'(m_ie));
        chk(req, "no redirect on return", 32'(redir_valid), 0);
    endtask

    task automatic t_normal();
        exc("R2 R4 R6 scall", 0, 1, 0, 0, 0, 32'h200, 32'h10E0, 5'd30);
        ret("R8 ret30", 5'd30);
        exc("R2 R4 R6 div0", 0, 0, 1, 0, 0, 32'h300, 32'h10A0, 5'd30);
        ret("R8 ret30", 5'd30);
        exc("R11 unmapped", 0, 0, 0, 1, 0, 32'h404, 32'h1080, 5'd30);
        ret("R8 ret30", 5'd30);
        exc("R11 misaligned", 0, 0, 0, 0, 1, 32'h408, 32'h1080, 5'd30);
        ret("R8 ret30", 5'd30);
    endtask

    task automatic t_break();
        exc("R3 R5 R7 break", 1, 0, 0, 0, 0, 32'h500, 32'h8020, 5'd31);
        ret("R8 ret31", 5'd31);
        ret("R8 other reg", 5'd5);
        chk("R8", "ie restored", 32'(ie), 32'h1);
    endtask

    task automatic t_priority();
        exc("R12 all four", 1, 1, 1, 1, 1, 32'h600, 32'h8020, 5'd31);
        ret("R12 ret31", 5'd31);
        exc("R12 div0 over scall", 0, 1, 1, 0, 0, 32'h604, 32'h10A0, 5'd30);
        ret("R12 ret30", 5'd30);
        exc("R12 dbus over scall", 0, 1, 0, 1, 0, 32'h608, 32'h1080, 5'd30);
        ret("R12 ret30", 5'd30);
    endtask

    task automatic t_collision();
        // system call together with a base write: old base used, new base kept
        scall_req = 1; fault_pc = 32'h700;
        csr_we = 1; csr_sel = 2'd2; csr_wdata = 32'h2000;
        @(negedge clk); idle();
        m_ie = {1'b0, m_ie[0], 1'b0}; m_eba = 32'h2000;
        chk("R12", "redir uses old eba", redir_pc, 32'h10E0);
        chk("R12", "eba written", eba, m_eba);
        chk("R12", "ie exception", 32'(ie), 32'(m_ie));
        // exception overrides enable write
        div0_req = 1; fault_pc = 32'h704;
        csr_we = 1; csr_sel = 2'd0; csr_wdata = 32'h7;
        @(negedge clk); idle();
        m_ie = {1'b0, m_ie[0], 1'b0};
        chk("R12", "exception beats ie write", 32'(ie), 32'(m_ie));
        chk("R12", "redir new eba", redir_pc, 32'h20A0);
        // return through r30 overrides enable write
        csr_wr(2'd0, 32'h3); m_ie = 3'b011;
        ret_valid = 1; ret_reg = 5'd30; csr_we = 1; csr_sel = 2'd0; csr_wdata = 32'h4;
        @(negedge clk); idle();
        m_ie = 3'b001;
        chk("R12", "return beats ie write", 32'(ie), 32'(m_ie));
    endtask

    task automatic t_pending();
        irq_raise = 32'hF0;
        @(negedge clk); idle(); m_ip = 32'hF0;
        chk("R9", "raise", ip, m_ip);
        csr_wr(2'd1, 32'h30); m_ip = 32'hC0;
        chk("R9", "w1c", ip, m_ip);
        csr_wr(2'd1, 32'h0);
        chk("R9", "write zero no effect", ip, m_ip);
        irq_raise = 32'h10; csr_we = 1; csr_sel = 2'd1; csr_wdata = 32'h90;
        @(negedge clk); idle(); m_ip = 32'h50;
        chk("R9", "raise beats clear", ip, m_ip);
        chk_csrs("R10");
    endtask

    task automatic t_held();
        scall_req = 1; fault_pc = 32'h800;
        @(negedge clk);
        chk("R13", "first cycle", 32'(redir_valid), 1);
        @(negedge clk); idle();
        chk("R13", "second cycle", 32'(redir_valid), 1);
        chk("R2", "second save", rf_wdata, 32'h800);
        @(negedge clk);
        chk("R13", "drop", 32'(redir_valid), 0);
    endtask

    initial begin
        #400000;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        idle();
        m_ie = '0; m_ip = '0; m_eba = '0; m_deba = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_csr_write();
        t_normal();
        t_break();
        t_priority();
        t_collision();
        t_pending();
        t_held();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule